// File: doc/BRIEF.md
# Write-Completion Status Poller

This block runs on the host side of a byte-wide nonvolatile memory. After the host has loaded a page of data, it starts the poller. The poller then issues a series of ordinary read cycles and works out when the memory's internal programming has finished. It owns the chip-enable, output-enable and write-enable strobes and the address bus while it runs. It samples the data bus at the end of each read cycle. The length of each read strobe, the idle gap between reads and a completion timeout are all counted in clock cycles, so one design can serve several speed grades and clock rates.

Two detection methods are offered. The first is data polling, selected with `mode` = 0. The poller reads back the last written address, whose address and data byte it saves at start. Bit 7 of a read comes back inverted while programming runs. The write is complete when bit 7 matches the saved byte. The second is toggle polling, selected with `mode` = 1. Here bit 6 flips on every read while programming runs. The write is complete when two back-to-back reads return the same bit 6, and the first read of a run only seeds the comparison. Neither method needs an interrupt line. If completion is not seen in time, the poller stops and flags a timeout. The timeout is sized by software to cover the memory's worst-case programming time of 5 ms.

Top module: `wcp_poller`

## Requirements
- R1: During and after reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, and `busy`, `done` and `timeout` are low.
- R2: Each poll read holds `mem_ce_n` and `mem_oe_n` low together for exactly `cfg_rd_cycles` clock cycles, where a value of 0 acts as 1. The bus is sampled on the last of those cycles. `mem_we_n` stays high at all times.
- R3: Between two poll reads, `mem_oe_n` and `mem_ce_n` are high for exactly `cfg_gap_cycles` cycles, where a value of 0 acts as 1.
- R4: With `mode` = 0, the poll completes on the first read whose bit 7 equals bit 7 of the saved data byte. `busy` falls and `done` rises on the clock edge that ends that read.
- R5: With `mode` = 1, the poll completes on the first read whose bit 6 equals bit 6 of the read just before it. The first read of a run never completes the poll, whatever it returns.
- R6: If no completion is seen within `cfg_timeout` busy cycles, where a value of 0 acts as 1, `timeout` rises and `busy` falls after exactly that many busy cycles. A completion found on the last allowed cycle gives `done` instead.
- R7: A `start` pulse while idle begins a poll and clears `done` and `timeout` on the next cycle. Between polls, `done` or `timeout` holds until the next start. A `start` pulse while `busy` is high is ignored.
- R8: `mode`, `poll_addr` and `poll_data` are captured when a poll starts. `mem_addr` shows the captured address for the whole poll. Changing these inputs during a poll has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a poll run |
| mode | input | 1 | 0 = data polling on bit 7, 1 = toggle polling on bit 6 |
| poll_addr | input | ADDR_W | Address to read (the last written address in data mode) |
| poll_data | input | 8 | Last written data byte |
| cfg_rd_cycles | input | CYC_W | Cycles the read strobes stay low per poll |
| cfg_gap_cycles | input | CYC_W | Cycles of idle bus between polls |
| cfg_timeout | input | TMO_W | Busy-cycle limit before timeout |
| mem_dq_in | input | 8 | Data bus from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, held high |
| mem_addr | output | ADDR_W | Address driven to the memory |
| busy | output | 1 | Poll run in progress |
| done | output | 1 | Programming finished |
| timeout | output | 1 | Completion not seen within the limit |

## Verification
A memory model returns inverted bit 7 and flipping bit 6 for a chosen number of reads, then returns the true byte. Data mode is run with zero and several busy reads, which separates completion on the first read from a late match. Toggle mode is run with the final true bit 6 both equal to and different from the last toggled value, which shows whether the comparison is against the previous read rather than a fixed value. A memory that is ready at once shows that the seed read alone never completes the poll. The timeout is set one cycle below and exactly at the completion time to pin down that completion wins on the limit cycle. One run changes the inputs and pulses start mid-poll to show that they are ignored.

// File: rtl/wcp_pkg.sv
package wcp_pkg;

    localparam int DQ_W   = 8;
    localparam int DP_BIT = 7;
    localparam int TG_BIT = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_GAP,
        ST_DONE,
        ST_TMO
    } wcp_state_e;

    typedef enum logic {
        MODE_DATA   = 1'b0,
        MODE_TOGGLE = 1'b1
    } wcp_mode_e;

    typedef struct packed {
        logic            seeded;
        logic [DQ_W-1:0] value;
    } poll_snap_t;

    function automatic logic data_poll_hit(input logic [DQ_W-1:0] rd,
                                           input logic [DQ_W-1:0] ref_byte);
        return rd[DP_BIT] == ref_byte[DP_BIT];
    endfunction

    function automatic logic toggle_hit(input logic [DQ_W-1:0] rd,
                                        input poll_snap_t prev);
        return prev.seeded && (rd[TG_BIT] == prev.value[TG_BIT]);
    endfunction

endpackage

// File: rtl/wcp_phase_timer.sv
module wcp_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] cnt;
    logic [CW-1:0] eff_val;

    assign eff_val = (load_val == '0) ? ONE : load_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= ONE;
        end else if (load) begin
            cnt <= eff_val;
        end else if (cnt > ONE) begin
            cnt <= cnt - ONE;
        end
    end

    assign last = (cnt == ONE);
endmodule

// File: rtl/wcp_judge.sv
module wcp_judge
    import wcp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            sample_en,
    input  wcp_mode_e       mode,
    input  logic [DQ_W-1:0] ref_byte,
    input  logic [DQ_W-1:0] dq_in,
    output logic            hit
);
    poll_snap_t prev;

    always_comb begin
        hit = 1'b0;
        if (sample_en) begin
            if (mode == MODE_DATA) hit = data_poll_hit(dq_in, ref_byte);
            else                   hit = toggle_hit(dq_in, prev);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev <= '0;
        end else if (sample_en) begin
            prev.seeded <= 1'b1;
            prev.value  <= dq_in;
        end
    end
endmodule

// File: rtl/wcp_watchdog.sv
module wcp_watchdog #(
    parameter int TW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

    logic [TW-1:0] elapsed;
    logic [TW-1:0] eff_lim;

    assign eff_lim = (limit == '0) ? ONE : limit;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            elapsed <= '0;
        end else if (run && (elapsed != '1)) begin
            elapsed <= elapsed + ONE;
        end
    end

    assign expire = run && (elapsed >= eff_lim - ONE);
endmodule

// File: rtl/wcp_poller.sv
module wcp_poller
    import wcp_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int CYC_W  = 8,
    parameter int TMO_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode,
    input  logic [ADDR_W-1:0] poll_addr,
    input  logic [DQ_W-1:0]   poll_data,
    input  logic [CYC_W-1:0]  cfg_rd_cycles,
    input  logic [CYC_W-1:0]  cfg_gap_cycles,
    input  logic [TMO_W-1:0]  cfg_timeout,
    input  logic [DQ_W-1:0]   mem_dq_in,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              done,
    output logic              timeout
);
    wcp_state_e        state, state_nx;
    wcp_mode_e         job_mode;
    logic [ADDR_W-1:0] job_addr;
    logic [DQ_W-1:0]   job_data;

    logic              accept;
    logic              phase_last;
    logic              tmr_load;
    logic [CYC_W-1:0]  tmr_val;
    logic              sample_en;
    logic              hit;
    logic              expire;

    assign busy   = (state == ST_READ) || (state == ST_GAP);
    assign accept = start && !busy;

    wcp_phase_timer #(.CW(CYC_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (phase_last)
    );

    assign sample_en = (state == ST_READ) && phase_last;

    wcp_judge u_judge (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .sample_en (sample_en),
        .mode      (job_mode),
        .ref_byte  (job_data),
        .dq_in     (mem_dq_in),
        .hit       (hit)
    );

    wcp_watchdog #(.TW(TMO_W)) u_wdog (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .run    (busy),
        .limit  (cfg_timeout),
        .expire (expire)
    );

    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = cfg_rd_cycles;
        unique case (state)
            ST_IDLE, ST_DONE, ST_TMO: begin
                if (start) begin
                    state_nx = ST_READ;
                    tmr_load = 1'b1;
                end
            end
            ST_READ: begin
                if (phase_last && hit) begin
                    state_nx = ST_DONE;
                end else if (expire) begin
                    state_nx = ST_TMO;
                end else if (phase_last) begin
                    state_nx = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = cfg_gap_cycles;
                end
            end
            ST_GAP: begin
                if (expire) begin
                    state_nx = ST_TMO;
                end else if (phase_last) begin
                    state_nx = ST_READ;
                    tmr_load = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            job_mode <= MODE_DATA;
            job_addr <= '0;
            job_data <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                job_mode <= wcp_mode_e'(mode);
                job_addr <= poll_addr;
                job_data <= poll_data;
            end
        end
    end

    assign mem_oe_n = (state != ST_READ);
    assign mem_ce_n = (state != ST_READ);
    assign mem_we_n = 1'b1;
    assign mem_addr = job_addr;
    assign done     = (state == ST_DONE);
    assign timeout  = (state == ST_TMO);
endmodule

// File: rtl/wcp_poller_chk.sv
module wcp_poller_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              done,
    input logic              timeout
);
    a_r2_oe_needs_ce: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_ce_n);

    a_r2_we_idle: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> mem_we_n);

    a_r8_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mem_addr));

    a_r6_end_flag: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done || timeout));

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && timeout));

    a_r4_done_idle_bus: assert property (@(posedge clk) disable iff (rst)
        (done || timeout) |-> (!busy && mem_oe_n));

    a_r7_start_clears: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done && !timeout));
endmodule

bind wcp_poller wcp_poller_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .mem_addr (mem_addr),
    .busy     (busy),
    .done     (done),
    .timeout  (timeout)
);

// File: tb/wcp_poller_bench.sv
`timescale 1ns/1ps
module wcp_poller_bench;
    localparam int ADDR_W = 13;
    localparam int CYC_W  = 8;
    localparam int TMO_W  = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              mode = 1'b0;
    logic [ADDR_W-1:0] poll_addr = '0;
    logic [7:0]        poll_data = '0;
    logic [CYC_W-1:0]  cfg_rd_cycles = 8'd1;
    logic [CYC_W-1:0]  cfg_gap_cycles = 8'd1;
    logic [TMO_W-1:0]  cfg_timeout = 24'd1000;
    logic [7:0]        mem_dq_in;
    logic              mem_ce_n, mem_oe_n, mem_we_n;
    logic [ADDR_W-1:0] mem_addr;
    logic              busy, done, timeout;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // memory model state
    int   reads_seen = 0;
    int   m_base = 0;
    int   m_k = 0;
    bit   m_t0 = 1'b0;
    logic [7:0] m_d = 8'h00;
    logic prev_oe = 1'b1;

    always #2.5 clk = ~clk;

    wcp_poller #(.ADDR_W(ADDR_W), .CYC_W(CYC_W), .TMO_W(TMO_W)) u_wcp_poller (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .poll_addr(poll_addr), .poll_data(poll_data),
        .cfg_rd_cycles(cfg_rd_cycles), .cfg_gap_cycles(cfg_gap_cycles),
        .cfg_timeout(cfg_timeout), .mem_dq_in(mem_dq_in),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .busy(busy), .done(done), .timeout(timeout)
    );

    always @(posedge clk) begin
        prev_oe <= mem_oe_n;
        if (!prev_oe && mem_oe_n) reads_seen <= reads_seen + 1;
    end

    always_comb begin
        int idx;
        idx = reads_seen - m_base;
        if (idx < m_k) mem_dq_in = {~m_d[7], m_t0 ^ idx[0], m_d[5:0]};
        else           mem_dq_in = m_d;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog R6: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int tog_reads(input int k, input bit t0, input bit d6);
        for (int j = 1; j < k + 4; j++) begin
            bit a, b;
            a = (j < k) ? (t0 ^ j[0]) : d6;
            b = ((j - 1) < k) ? (t0 ^ (j - 1) % 2 == 1) : d6;
            if (a == b) return j + 1;
        end
        return -1;
    endfunction

    // one poll run; exp_to selects timeout expectation
    task automatic run_poll(input string name, input bit md, input int k,
                            input bit t0, input logic [7:0] d,
                            input logic [ADDR_W-1:0] addr,
                            input int rd, input int gap, input int tmo,
                            input bit disturb, input bit exp_to);
        int exp_reads, exp_busy;
        int busy_cnt, reads, low_run, high_run;
        int bad_low, bad_high, bad_addr, bad_we;
        bit last_oe;
        exp_reads = md ? tog_reads(k, t0, d[6]) : k + 1;
        exp_busy  = exp_to ? eff(tmo)
                           : exp_reads * eff(rd) + (exp_reads - 1) * eff(gap);

        @(negedge clk);
        m_base = reads_seen;
        m_k = k; m_t0 = t0; m_d = d;
        mode = md; poll_addr = addr; poll_data = d;
        cfg_rd_cycles = rd[CYC_W-1:0]; cfg_gap_cycles = gap[CYC_W-1:0];
        cfg_timeout = tmo[TMO_W-1:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({name, " R7 start clears flags"}, {busy, done, timeout}, 3'b100);

        busy_cnt = 0; reads = 0; low_run = 0; high_run = 0;
        bad_low = 0; bad_high = 0; bad_addr = 0; bad_we = 0;
        last_oe = 1'b1;
        while (busy && busy_cnt < 20000) begin
            busy_cnt++;
            if (!mem_we_n) bad_we++;
            if (!mem_oe_n) begin
                if (mem_ce_n) bad_we++;
                if (mem_addr != addr) bad_addr++;
                if (last_oe) begin
                    reads++;
                    if (reads > 1 && high_run != eff(gap)) bad_high++;
                    low_run = 0;
                end
                low_run++;
            end else begin
                if (!last_oe) begin
                    if (low_run != eff(rd)) bad_low++;
                    high_run = 0;
                end
                high_run++;
            end
            last_oe = mem_oe_n;
            if (disturb && busy_cnt == 3) begin
                start = 1'b1; mode = ~md; poll_addr = ~addr; poll_data = ~d;
            end
            if (disturb && busy_cnt == 4) start = 1'b0;
            @(negedge clk);
        end
        if (!exp_to && low_run != eff(rd)) bad_low++;

        chk({name, " busy cycles R6"}, busy_cnt, exp_busy);
        if (exp_to) begin
            chk({name, " R6 timeout flag"}, {done, timeout}, 2'b01);
        end else begin
            chk({name, md ? " R5 done flag" : " R4 done flag"}, {done, timeout}, 2'b10);
            chk({name, md ? " R5 read count" : " R4 read count"}, reads, exp_reads);
            chk({name, " R2 read strobe length"}, bad_low, 0);
            chk({name, " R3 gap length"}, bad_high, 0);
        end
        chk({name, " R8 address held"}, bad_addr, 0);
        chk({name, " R2 write enable high"}, bad_we, 0);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk({name, " R7 flag holds"}, {busy, done, timeout}, exp_to ? 3'b001 : 3'b010);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        chk("R1 reset flags", {busy, done, timeout}, 3'b000);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", {busy, done, timeout, mem_oe_n}, 4'b0001);
    endtask

    initial begin
        t_reset();
        // R4 data polling, several busy reads
        run_poll("data_k3",  1'b0, 3, 1'b0, 8'h35, 13'h1abc, 3, 2, 1000, 1'b0, 1'b0);
        // R4 ready at once, zero configs act as one (R2 R3)
        run_poll("data_k0",  1'b0, 0, 1'b0, 8'hc2, 13'h0042, 0, 0, 1000, 1'b0, 1'b0);
        // R5 toggle, true bit equals last toggled value
        run_poll("tog_same", 1'b1, 4, 1'b0, 8'h40, 13'h0100, 2, 1, 1000, 1'b0, 1'b0);
        // R5 toggle, true bit differs from last toggled value
        run_poll("tog_diff", 1'b1, 4, 1'b0, 8'h00, 13'h0101, 2, 3, 1000, 1'b0, 1'b0);
        // R5 seed read alone never completes
        run_poll("tog_seed", 1'b1, 0, 1'b1, 8'h7f, 13'h0555, 1, 1, 1000, 1'b0, 1'b0);
        // R6 timeout while programming never ends
        run_poll("data_tmo", 1'b0, 100, 1'b0, 8'h81, 13'h0aaa, 2, 2, 20, 1'b0, 1'b1);
        // R6 boundary: limit equals completion time -> done
        run_poll("edge_ok",  1'b0, 2, 1'b0, 8'h11, 13'h0200, 2, 2, 10, 1'b0, 1'b0);
        // R6 boundary: one cycle short -> timeout
        run_poll("edge_tmo", 1'b0, 2, 1'b0, 8'h11, 13'h0200, 2, 2, 9, 1'b0, 1'b1);
        // R7 R8 start and input changes mid-poll ignored
        run_poll("disturb",  1'b0, 3, 1'b0, 8'h5a, 13'h1234, 2, 2, 1000, 1'b1, 1'b0);
        run_poll("disturb_t",1'b1, 3, 1'b1, 8'h5a, 13'h0321, 2, 2, 1000, 1'b1, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule